// File: doc/BRIEF.md
# Processor-Side Interrupt Interface

This block sits between an interrupt distributor and one processor. Each cycle the distributor presents its most urgent pending interrupt as an ID and an 8-bit priority. The block raises a request line to the processor when that candidate is allowed through. A candidate is allowed through when the interface is enabled, its priority value is below a programmable threshold, it is more urgent than the interrupt currently being handled, and there is room to nest one more level. A lower priority value means a more urgent interrupt.

Software uses a 32-bit register port. A read of the claim register takes the candidate, pushes it onto a small stack of active interrupts, makes its priority the running priority, and sends a one-cycle activate strobe with the ID back to the distributor. If nothing can be taken, the read returns the spurious code 1023 and changes nothing. Software completes an interrupt by writing its ID to the completion register. A matching write pops the stack, restores the outer running priority and sends a one-cycle deactivate strobe. Writes that do not match are ignored.

The request line and the read data are combinational from the current inputs and state. The strobes are registered, so they appear in the cycle after the access.

Top module: `irq_cpu_port`

## Requirements
- R1: Bit 0 of the control register (offset 0x000, reset 0) enables signalling. While it is 0, `irq_out` stays low and a claim read returns 1023.
- R2: The threshold register (offset 0x004, bits [7:0], reset 0) passes only candidates whose priority is strictly below it. A threshold of 255 passes every priority up to 254.
- R3: A candidate is signalled only if its priority is strictly below the running priority. The running priority reads at offset 0x014 in bits [7:0], and reads 0xFF when no interrupt is active.
- R4: When a claim read at offset 0x00C happens while a request is raised, it returns the candidate ID in bits [9:0] with all upper bits zero. The running priority then becomes the candidate's priority. In the next cycle `act_pulse` is high for one cycle and `act_id` carries the ID.
- R5: A claim read while no request is raised returns 1023. It produces no activate strobe and changes no state.
- R6: The pending-view register at offset 0x018 returns the candidate ID when `cand_valid` is high and 1023 otherwise. Reading it has no side effect.
- R7: A write to offset 0x010 whose bits [9:0] equal the most recently claimed active ID, and whose bits [31:10] are zero, completes that interrupt. The running priority returns to the next outer level, or to 0xFF. In the next cycle `deact_pulse` is high for one cycle with `deact_id` set to the ID.
- R8: A completion write that does not match, or that arrives with no active interrupt, is ignored. It produces no strobe and the running priority is unchanged.
- R9: Up to NEST_DEPTH interrupts can be active at once. While all levels are in use, no request is raised and a claim read returns 1023.
- R10: Writes to the read-only offsets (0x00C, 0x014, 0x018) and to unmapped offsets have no effect. Reads of unmapped offsets return 0.
- R11: When `reg_rd` and `reg_wr` are both high in the same cycle, only the write takes effect. A claim read in that cycle does not take the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (side effects only at the claim offset) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| cand_valid | input | 1 | Distributor has a pending candidate |
| cand_id | input | 10 | Candidate interrupt ID |
| cand_prio | input | 8 | Candidate priority (lower is more urgent) |
| irq_out | output | 1 | Interrupt request to the processor |
| act_pulse | output | 1 | One-cycle activate strobe to the distributor |
| act_id | output | 10 | ID carried with the activate strobe |
| deact_pulse | output | 1 | One-cycle deactivate strobe to the distributor |
| deact_id | output | 10 | ID carried with the deactivate strobe |

## Verification
Most internal faults show up at the ports within one access. A wrong stack top or depth count appears at once as a wrong value in the running-priority register. It also changes whether `irq_out` rises for the next candidate in the same cycle. A lost push or pop shows up one cycle after the access as a missing or extra activate or deactivate strobe. A completion ID that compares against the wrong stack level shows up as a strobe on a mismatched write, or as none on a matched write. The reference model mirrors the stack as a queue and checks the request line, the read data and both strobes on every cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int ID_W   = 10;
  localparam int PRIO_W = 8;
  localparam logic [ID_W-1:0]   SPURIOUS_ID = 10'd1023;
  localparam logic [PRIO_W-1:0] PRIO_IDLE   = 8'hFF;

  localparam int OFF_CTRL  = 'h000;
  localparam int OFF_MASK  = 'h004;
  localparam int OFF_CLAIM = 'h00C;
  localparam int OFF_DONE  = 'h010;
  localparam int OFF_RUN   = 'h014;
  localparam int OFF_PEND  = 'h018;

  // A candidate passes when the interface is on, a slot is free, and the
  // candidate is strictly more urgent than both the threshold and the
  // running level.
  function automatic logic may_signal(
    input logic              en,
    input logic              valid,
    input logic              full,
    input logic [PRIO_W-1:0] prio,
    input logic [PRIO_W-1:0] thresh,
    input logic [PRIO_W-1:0] running
  );
    return en && valid && !full && (prio < thresh) && (prio < running);
  endfunction
endpackage

// File: rtl/irqc_regfile.sv
module irqc_regfile
  import irqc_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PRIO_W-1:0] wdata_lo,
  input  logic [ID_W-1:0]   claim_value,
  input  logic [PRIO_W-1:0] running,
  input  logic [ID_W-1:0]   pend_value,
  output logic              en_q,
  output logic [PRIO_W-1:0] thresh_q,
  output logic [31:0]       rdata
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFF_MASK);
  localparam logic [ADDR_W-1:0] A_CLAIM = ADDR_W'(OFF_CLAIM);
  localparam logic [ADDR_W-1:0] A_RUN   = ADDR_W'(OFF_RUN);
  localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(OFF_PEND);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      thresh_q <= '0;
    end else if (wr_en) begin
      if (addr == A_CTRL) en_q     <= wdata_lo[0];
      if (addr == A_MASK) thresh_q <= wdata_lo;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_CTRL)  rdata = {31'b0, en_q};
    if (addr == A_MASK)  rdata = {{(32-PRIO_W){1'b0}}, thresh_q};
    if (addr == A_CLAIM) rdata = {{(32-ID_W){1'b0}}, claim_value};
    if (addr == A_RUN)   rdata = {{(32-PRIO_W){1'b0}}, running};
    if (addr == A_PEND)  rdata = {{(32-ID_W){1'b0}}, pend_value};
  end
endmodule

// File: rtl/irqc_active_stack.sv
module irqc_active_stack
  import irqc_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ID_W-1:0]   push_id,
  input  logic [PRIO_W-1:0] push_prio,
  input  logic              pop,
  output logic [ID_W-1:0]   top_id,
  output logic [PRIO_W-1:0] running,
  output logic              empty,
  output logic              full
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0]  count_q;
  logic [ID_W-1:0]   id_q   [DEPTH];
  logic [PRIO_W-1:0] prio_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        id_q[g]   <= '0;
        prio_q[g] <= PRIO_IDLE;
      end else if (push && count_q == CNT_W'(g)) begin
        id_q[g]   <= push_id;
        prio_q[g] <= push_prio;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    count_q <= '0;
    else if (push) count_q <= count_q + 1'b1;
    else if (pop)  count_q <= count_q - 1'b1;
  end

  always_comb begin
    top_id  = '0;
    running = PRIO_IDLE;
    for (int i = 0; i < DEPTH; i++) begin
      if (count_q == CNT_W'(i + 1)) begin
        top_id  = id_q[i];
        running = prio_q[i];
      end
    end
  end

  assign empty = (count_q == '0);
  assign full  = (count_q == CNT_W'(DEPTH));
endmodule

// File: rtl/irqc_pulse_reg.sv
module irqc_pulse_reg #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fire,
  input  logic [W-1:0] tag,
  output logic         pulse_q,
  output logic [W-1:0] tag_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      tag_q   <= '0;
    end else begin
      pulse_q <= fire;
      if (fire) tag_q <= tag;
    end
  end
endmodule

// File: rtl/irq_cpu_port.sv
module irq_cpu_port
  import irqc_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int NEST_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              cand_valid,
  input  logic [9:0]        cand_id,
  input  logic [7:0]        cand_prio,
  output logic              irq_out,
  output logic              act_pulse,
  output logic [9:0]        act_id,
  output logic              deact_pulse,
  output logic [9:0]        deact_id
);
  localparam logic [ADDR_W-1:0] A_CLAIM = ADDR_W'(OFF_CLAIM);
  localparam logic [ADDR_W-1:0] A_DONE  = ADDR_W'(OFF_DONE);

  logic              ctrl_en;
  logic [PRIO_W-1:0] thresh;
  logic [PRIO_W-1:0] running;
  logic [ID_W-1:0]   top_id;
  logic              stk_empty, stk_full;

  // Named internal events for the checker.
  logic              signalable;
  logic              claim_rd;
  logic              claim_take;
  logic              done_wr;
  logic              done_match;
  logic [ID_W-1:0]   done_id;
  logic [ID_W-1:0]   claim_value;
  logic [ID_W-1:0]   pend_value;

  assign signalable  = may_signal(ctrl_en, cand_valid, stk_full, cand_prio, thresh, running);
  assign claim_rd    = reg_rd && !reg_wr && (reg_addr == A_CLAIM);
  assign claim_take  = claim_rd && signalable;
  assign done_wr     = reg_wr && (reg_addr == A_DONE);
  assign done_id     = reg_wdata[ID_W-1:0];
  assign done_match  = done_wr && !stk_empty && (reg_wdata[31:ID_W] == '0) && (done_id == top_id);
  assign claim_value = signalable ? cand_id : SPURIOUS_ID;
  assign pend_value  = cand_valid ? cand_id : SPURIOUS_ID;
  assign irq_out     = signalable;

  irqc_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (reg_wr),
    .addr        (reg_addr),
    .wdata_lo    (reg_wdata[PRIO_W-1:0]),
    .claim_value (claim_value),
    .running     (running),
    .pend_value  (pend_value),
    .en_q        (ctrl_en),
    .thresh_q    (thresh),
    .rdata       (reg_rdata)
  );

  irqc_active_stack #(.DEPTH(NEST_DEPTH)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (claim_take),
    .push_id   (cand_id),
    .push_prio (cand_prio),
    .pop       (done_match),
    .top_id    (top_id),
    .running   (running),
    .empty     (stk_empty),
    .full      (stk_full)
  );

  irqc_pulse_reg #(.W(ID_W)) u_act (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (claim_take),
    .tag     (cand_id),
    .pulse_q (act_pulse),
    .tag_q   (act_id)
  );

  irqc_pulse_reg #(.W(ID_W)) u_deact (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (done_match),
    .tag     (done_id),
    .pulse_q (deact_pulse),
    .tag_q   (deact_id)
  );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_out,
  input logic       ctrl_en,
  input logic [7:0] thresh,
  input logic [7:0] running,
  input logic       stk_full,
  input logic [9:0] cand_id,
  input logic [7:0] cand_prio,
  input logic       claim_take,
  input logic       done_wr,
  input logic       done_match,
  input logic [9:0] done_id,
  input logic       act_pulse,
  input logic [9:0] act_id,
  input logic       deact_pulse,
  input logic [9:0] deact_id
);
  assert_off_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |-> !irq_out);

  assert_below_thresh_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> cand_prio < thresh);

  assert_below_running_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> cand_prio < running);

  assert_claim_effect_R4: assert property (@(posedge clk) disable iff (!rst_n)
    claim_take |=> act_pulse && act_id == $past(cand_id) && running == $past(cand_prio));

  assert_done_effect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_match |=> deact_pulse && deact_id == $past(done_id));

  assert_done_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_wr && !done_match) |=> !deact_pulse && $stable(running));

  assert_full_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stk_full |-> !irq_out);

  assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(act_pulse && deact_pulse));
endmodule

bind irq_cpu_port irqc_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .irq_out     (irq_out),
  .ctrl_en     (ctrl_en),
  .thresh      (thresh),
  .running     (running),
  .stk_full    (stk_full),
  .cand_id     (cand_id),
  .cand_prio   (cand_prio),
  .claim_take  (claim_take),
  .done_wr     (done_wr),
  .done_match  (done_match),
  .done_id     (done_id),
  .act_pulse   (act_pulse),
  .act_id      (act_id),
  .deact_pulse (deact_pulse),
  .deact_id    (deact_id)
);

// File: tb/tb_irq_cpu_port.sv
module tb_irq_cpu_port;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cand_valid = 1'b0;
  logic [9:0]  cand_id = '0;
  logic [7:0]  cand_prio = 8'hFF;
  logic        irq_out, act_pulse, deact_pulse;
  logic [9:0]  act_id, deact_id;

  always #5 clk = ~clk;

  irq_cpu_port #(.ADDR_W(12), .NEST_DEPTH(DEPTH)) dut (.*);

  int n_checks = 0, n_fail = 0;

  // Reference state
  bit en_m = 0;
  int mask_m = 0;
  int id_st[$];
  int pr_st[$];

  function automatic int run_m();
    return (pr_st.size() > 0) ? pr_st[pr_st.size()-1] : 255;
  endfunction

  function automatic bit sig_m(bit cv, int cp);
    return en_m && cv && (id_st.size() < DEPTH) && (cp < mask_m) && (cp < run_m());
  endfunction

  task automatic chk(string req, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(bit rd, bit wr, int a, int wd, bit cv, int cid, int cp, string req);
    bit s, e_act, e_deact;
    longint e_rd;
    reg_rd = rd; reg_wr = wr; reg_addr = 12'(a); reg_wdata = 32'(wd);
    cand_valid = cv; cand_id = 10'(cid); cand_prio = 8'(cp);
    #1;
    s = sig_m(cv, cp);
    chk({req, " irq"}, irq_out, s);
    if (rd) begin
      case (a)
        'h000: e_rd = en_m;
        'h004: e_rd = mask_m;
        'h00C: e_rd = s ? cid : 1023;
        'h014: e_rd = run_m();
        'h018: e_rd = cv ? cid : 1023;
        default: e_rd = 0;
      endcase
      chk({req, " rdata"}, reg_rdata, e_rd);
    end
    e_act   = rd && !wr && a == 'h00C && s;
    e_deact = wr && a == 'h010 && id_st.size() > 0 && wd == id_st[id_st.size()-1];
    @(posedge clk);
    if (wr && a == 'h000) en_m = wd[0];
    if (wr && a == 'h004) mask_m = wd & 'hFF;
    if (e_deact) begin void'(id_st.pop_back()); void'(pr_st.pop_back()); end
    if (e_act) begin id_st.push_back(cid); pr_st.push_back(cp); end
    @(negedge clk);
    chk({req, " act"}, act_pulse, e_act);
    if (e_act) chk({req, " act_id"}, act_id, cid);
    chk({req, " deact"}, deact_pulse, e_deact);
    if (e_deact) chk({req, " deact_id"}, deact_id, wd);
  endtask

  initial begin
    #1000000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // Reset state
    step(1, 0, 'h000, 0, 0, 0, 255, "R1 reset ctrl");
    step(1, 0, 'h004, 0, 0, 0, 255, "R2 reset mask");
    step(1, 0, 'h014, 0, 0, 0, 255, "R3 idle running");
    step(1, 0, 'h00C, 0, 1, 5, 'h10, "R1 disabled claim");
    // Threshold
    step(0, 1, 'h000, 1, 1, 5, 'h10, "R1 enable");
    step(0, 1, 'h004, 'h80, 1, 7, 'h90, "R2 set mask");
    step(0, 0, 0, 0, 1, 7, 'h90, "R2 above");
    step(0, 0, 0, 0, 1, 7, 'h80, "R2 equal");
    step(0, 0, 0, 0, 1, 7, 'h7F, "R2 below");
    // Claim
    step(1, 0, 'h00C, 0, 1, 7, 'h40, "R4 claim");
    step(1, 0, 'h014, 0, 1, 7, 'h40, "R4 running");
    step(1, 0, 'h00C, 0, 1, 9, 'h40, "R5 equal prio claim");
    step(1, 0, 'h00C, 0, 1, 9, 'h20, "R3 nested claim");
    // Pending view
    step(1, 0, 'h018, 0, 1, 12, 'h50, "R6 pend valid");
    step(1, 0, 'h018, 0, 0, 12, 'h10, "R6 pend none");
    step(1, 0, 'h014, 0, 0, 0, 255, "R6 no side effect");
    // Completion
    step(0, 1, 'h010, 7, 0, 0, 255, "R8 mismatch");
    step(1, 0, 'h014, 0, 0, 0, 255, "R8 running kept");
    step(0, 1, 'h010, 9 | (1 << 12), 0, 0, 255, "R7 upper bits set");
    step(0, 1, 'h010, 9, 0, 0, 255, "R7 done inner");
    step(1, 0, 'h014, 0, 0, 0, 255, "R7 outer restored");
    step(0, 1, 'h010, 7, 0, 0, 255, "R7 done outer");
    step(0, 1, 'h010, 7, 0, 0, 255, "R8 empty");
    step(1, 0, 'h014, 0, 0, 0, 255, "R7 idle again");
    // Nesting to full
    step(1, 0, 'h00C, 0, 1, 1, 'h30, "R9 lvl1");
    step(1, 0, 'h00C, 0, 1, 2, 'h20, "R9 lvl2");
    step(1, 0, 'h00C, 0, 1, 3, 'h10, "R9 lvl3");
    step(1, 0, 'h00C, 0, 1, 4, 'h08, "R9 lvl4");
    step(1, 0, 'h00C, 0, 1, 5, 'h01, "R9 full claim");
    step(0, 1, 'h010, 4, 0, 0, 255, "R9 pop4");
    step(0, 1, 'h010, 3, 0, 0, 255, "R9 pop3");
    step(0, 1, 'h010, 2, 0, 0, 255, "R9 pop2");
    step(0, 1, 'h010, 1, 0, 0, 255, "R9 pop1");
    // Read-only and unmapped
    step(0, 1, 'h014, 0, 0, 0, 255, "R10 wr run");
    step(0, 1, 'h00C, 0, 1, 6, 'h10, "R10 wr claim");
    step(0, 1, 'h018, 0, 0, 0, 255, "R10 wr pend");
    step(0, 1, 'h100, 0, 0, 0, 255, "R10 wr unmapped");
    step(1, 0, 'h014, 0, 0, 0, 255, "R10 running");
    step(1, 0, 'h100, 0, 0, 0, 255, "R10 rd unmapped");
    step(1, 0, 'h004, 0, 0, 0, 255, "R10 mask kept");
    // Read and write together
    step(1, 1, 'h00C, 0, 1, 6, 'h10, "R11 rd+wr claim");
    step(1, 0, 'h014, 0, 0, 0, 255, "R11 nothing taken");
    // Full threshold
    step(0, 1, 'h004, 255, 1, 8, 254, "R2 mask max");
    step(1, 0, 'h00C, 0, 1, 8, 254, "R2 claim 254");
    step(0, 1, 'h010, 8, 0, 0, 255, "R7 done 8");
    // Disable again
    step(0, 1, 'h000, 0, 1, 8, 'h10, "R1 disable");
    step(1, 0, 'h00C, 0, 1, 8, 'h10, "R1 off claim");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule